// File: doc/BRIEF.md
# Scaled Saturating Pixel Pack Unit

This block turns wide signed fixed-point lanes into narrower values. Each lane is sign-extended to 64 bits and shifted left by a scale factor taken from a field of a status word. It is then shifted right arithmetically by an amount fixed for the operation, and clamped to the range of the destination. A two-bit operation select picks one of three conversions:

- four 16-bit lanes to unsigned bytes;
- two 32-bit lanes to unsigned bytes, laid into a byte-shifted copy of a second operand;
- two 32-bit lanes to signed 16-bit values.

A pipeline stage upstream presents the status word, a lane operand, a merge operand, the operation code and a valid strobe. The registered result comes back one cycle later with its own valid flag. Results narrower than 64 bits are zero-extended. Writing the status word is handled elsewhere.

Top module: `pixel_pack_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, `out_valid` and `out_data` become 0.
- R2: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high. When `in_valid` is low, `out_data` keeps its previous value.
- R3: Op code 0 (byte pack of 16-bit lanes) works on lane k = `lane_src[16k+15:16k]`, k = 0..3, taken as signed. The lane is shifted left by `status[6:3]` and then arithmetically right by 7. The value is clamped to 0..255 and placed in `out_data[8k+7:8k]`. `out_data[63:32]` is 0.
- R4: For op code 0, status bit 7 and all status bits outside [6:3] have no effect on the result.
- R5: Op code 1 (byte pack of 32-bit lanes) works on lane k = `lane_src[32k+31:32k]`, k = 0..1, taken as signed. The lane is shifted left by `status[7:3]` and then arithmetically right by 23. The value is clamped to 0..255 and placed in `out_data[32k+7:32k]`.
- R6: For op code 1, the result is otherwise `merge_src` shifted left by 8 bits. Bits [7:0] and [39:32] of that shifted value are replaced by the two lane bytes, so `out_data[31:8]` = `merge_src[23:0]` and `out_data[63:40]` = `merge_src[55:32]`.
- R7: Op code 2 (16-bit fixed pack) works on the 32-bit signed lanes with scale `status[7:3]`. The lane is shifted right arithmetically by 16 and clamped to -32768..32767. Lane 0 goes to `out_data[15:0]`, lane 1 goes to `out_data[31:16]`, and `out_data[63:32]` is 0.
- R8: The left shift loses no bits before clamping. A large lane with a large scale saturates instead of wrapping; for example, lane 0x4000_0000 with scale 31 under op code 2 gives 0x7FFF.
- R9: Op code 3 is reserved and gives `out_data` = 0 with `out_valid` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands valid this cycle |
| op_sel | input | 2 | Operation code: 0 byte pack of 16-bit lanes, 1 merged byte pack of 32-bit lanes, 2 fixed pack, 3 reserved |
| status | input | 64 | Status word; scale field at bits [7:3] |
| merge_src | input | 64 | Operand shifted and merged by op code 1 |
| lane_src | input | 64 | Fixed-point lanes to convert |
| out_valid | output | 1 | Result valid |
| out_data | output | 64 | Registered result |

## Verification
The hardest cases to reach are the saturation boundaries for a large scale. In these cases a lane shifted left by up to 31 bits would overflow a 32-bit intermediate, so a narrow datapath would wrap to a small in-range value instead of clamping. Random operands rarely land on these. Directed vectors therefore combine extreme lanes (0x4000_0000, 0x8000_0000, 0x7FFF, 1) with scales of 15 and 31. They also cover the exact clamp edges: a lane that lands on 255 without saturating, and one that lands on 256. Status words with every bit outside the scale field set show that the unused bits are ignored.

// File: rtl/pack_pkg.sv
// Package: shared operation codes and width constants for the pixel pack unit.
// Assumes a 64-bit datapath; op codes are decoded by the result selector.
package pack_pkg;
    localparam int WORD_W = 64;

    typedef enum logic [1:0] {
        OP_PIX16 = 2'd0,
        OP_PIX32 = 2'd1,
        OP_FIX16 = 2'd2,
        OP_RSVD  = 2'd3
    } pack_op_e;
endpackage

// File: rtl/pack_lane_sat.sv
// Module: one conversion lane. Sign-extends the input lane to WIDE_W bits,
// shifts it left by the scale, shifts right arithmetically by RSH and clamps
// to [LO, HI], returning the low OUT_W bits of the clamped value.
// Assumes IN_W + 2**SCL_W - 1 < WIDE_W so the left shift never loses bits.
module pack_lane_sat #(
    parameter int     IN_W   = 16,
    parameter int     SCL_W  = 4,
    parameter int     RSH    = 7,
    parameter int     OUT_W  = 8,
    parameter int     WIDE_W = 64,
    parameter longint LO     = 0,
    parameter longint HI     = 255
) (
    input  logic [IN_W-1:0]  lane_in,
    input  logic [SCL_W-1:0] scale,
    output logic [OUT_W-1:0] lane_out
);
    localparam int EXT_W = WIDE_W - IN_W;
    localparam logic signed [WIDE_W-1:0] LO_W = WIDE_W'(LO);
    localparam logic signed [WIDE_W-1:0] HI_W = WIDE_W'(HI);

    logic signed [WIDE_W-1:0] ext_val;
    logic signed [WIDE_W-1:0] scaled_val;
    logic signed [WIDE_W-1:0] adj_val;

    // Widen, scale up, then scale down by the fixed amount.
    always_comb begin
        ext_val    = {{EXT_W{lane_in[IN_W-1]}}, lane_in};
        scaled_val = ext_val <<< scale;
        adj_val    = scaled_val >>> RSH;
    end

    // Clamp to the destination range.
    always_comb begin
        if (adj_val < LO_W)
            lane_out = LO_W[OUT_W-1:0];
        else if (adj_val > HI_W)
            lane_out = HI_W[OUT_W-1:0];
        else
            lane_out = adj_val[OUT_W-1:0];
    end
endmodule

// File: rtl/pack_result_sel.sv
// Module: assembles the 64-bit result word for the selected operation from
// the lane outputs and, for the merged byte pack, the merge operand.
// Assumes lane outputs are already clamped; purely combinational.
module pack_result_sel
    import pack_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [1:0]   op_sel,
    input  logic [31:0]  pix16_bytes,
    input  logic [15:0]  pix32_bytes,
    input  logic [31:0]  fix_halves,
    input  logic [W-1:0] merge_src,
    output logic [W-1:0] result
);
    localparam int HALF = W / 2;
    localparam logic [W-1:0] HOLE_MASK = ~{{(HALF-8){1'b0}}, 8'hFF, {(HALF-8){1'b0}}, 8'hFF};

    logic [W-1:0] merged;

    // Byte-shifted copy of the merge operand with the two lane bytes inserted.
    always_comb begin
        merged              = (merge_src << 8) & HOLE_MASK;
        merged[7:0]         = pix32_bytes[7:0];
        merged[HALF+7:HALF] = pix32_bytes[15:8];
    end

    // Pick the result for the operation code.
    always_comb begin
        case (pack_op_e'(op_sel))
            OP_PIX16: result = {{(W-32){1'b0}}, pix16_bytes};
            OP_PIX32: result = merged;
            OP_FIX16: result = {{(W-32){1'b0}}, fix_halves};
            default:  result = '0;
        endcase
    end
endmodule

// File: rtl/pixel_pack_unit.sv
// Module: top of the scaled saturating pack unit. Extracts the scale fields
// from the status word, runs the lane converters for all three operations
// in parallel, selects the result and registers it with a valid flag.
// Assumes a synchronous active-low reset; status is loaded elsewhere.
module pixel_pack_unit
    import pack_pkg::*;
#(
    parameter int N16 = 4,
    parameter int N32 = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [1:0]  op_sel,
    input  logic [63:0] status,
    input  logic [63:0] merge_src,
    input  logic [63:0] lane_src,
    output logic        out_valid,
    output logic [63:0] out_data
);
    localparam int SCL16_W = 4;
    localparam int SCL32_W = 5;
    localparam int SCL_LSB = 3;

    logic [SCL16_W-1:0] scale16;
    logic [SCL32_W-1:0] scale32;
    logic [8*N16-1:0]   pix16_bytes;
    logic [8*N32-1:0]   pix32_bytes;
    logic [16*N32-1:0]  fix_halves;
    logic [63:0]        result;
    logic               unused_bits;

    // Scale fields from the status word.
    always_comb begin
        scale16 = status[SCL_LSB +: SCL16_W];
        scale32 = status[SCL_LSB +: SCL32_W];
    end

    assign unused_bits = ^{status[63:8], status[2:0], merge_src[63:56], merge_src[31:24]};

    // Four 16-bit lanes to unsigned bytes.
    for (genvar k = 0; k < N16; k++) begin : g_pix16
        pack_lane_sat #(.IN_W(16), .SCL_W(SCL16_W), .RSH(7), .OUT_W(8),
                        .WIDE_W(WORD_W), .LO(0), .HI(255)) u_lane (
            .lane_in (lane_src[16*k +: 16]),
            .scale   (scale16),
            .lane_out(pix16_bytes[8*k +: 8])
        );
    end

    // Two 32-bit lanes to unsigned bytes, and to signed halves.
    for (genvar k = 0; k < N32; k++) begin : g_lane32
        pack_lane_sat #(.IN_W(32), .SCL_W(SCL32_W), .RSH(23), .OUT_W(8),
                        .WIDE_W(WORD_W), .LO(0), .HI(255)) u_byte (
            .lane_in (lane_src[32*k +: 32]),
            .scale   (scale32),
            .lane_out(pix32_bytes[8*k +: 8])
        );
        pack_lane_sat #(.IN_W(32), .SCL_W(SCL32_W), .RSH(16), .OUT_W(16),
                        .WIDE_W(WORD_W), .LO(-32768), .HI(32767)) u_fix (
            .lane_in (lane_src[32*k +: 32]),
            .scale   (scale32),
            .lane_out(fix_halves[16*k +: 16])
        );
    end

    pack_result_sel #(.W(WORD_W)) u_sel (
        .op_sel     (op_sel),
        .pix16_bytes(pix16_bytes),
        .pix32_bytes(pix32_bytes),
        .fix_halves (fix_halves),
        .merge_src  (merge_src),
        .result     (result)
    );

    // Output register with valid flag; data holds while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_data <= result;
        end
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_data)));
    // R3
    pix16_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'd0) |=> (out_data[63:32] == 32'd0));
    // R6
    merge_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'd1) |=>
            (out_data[31:8] == $past(merge_src[23:0]) &&
             out_data[63:40] == $past(merge_src[55:32])));
    // R7
    fix_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'd2) |=> (out_data[63:32] == 32'd0));
    // R9
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'd3) |=> (out_data == 64'd0));
endmodule

// File: tb/tb_pixel_pack_unit.sv
module tb_pixel_pack_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op_sel = 2'd0;
    logic [63:0] status = '0;
    logic [63:0] merge_src = '0;
    logic [63:0] lane_src = '0;
    logic        out_valid;
    logic [63:0] out_data;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 0;
    bit    exp_valid = 0;
    logic [63:0] exp_data = '0;
    string exp_tag = "R2";

    always #5 clk = ~clk;

    pixel_pack_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .status(status), .merge_src(merge_src), .lane_src(lane_src),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic longint clampv(longint v, longint lo, longint hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    // Behavioural reference from the requirements.
    function automatic logic [63:0] ref_pack(logic [1:0] op, logic [63:0] g,
                                             logic [63:0] a, logic [63:0] b);
        logic [63:0] r = '0;
        longint v;
        int s4 = int'(g[6:3]);
        int s5 = int'(g[7:3]);
        case (op)
            2'd0: for (int k = 0; k < 4; k++) begin
                v = longint'($signed(b[16*k +: 16]));
                v = clampv((v <<< s4) >>> 7, 0, 255);
                r[8*k +: 8] = v[7:0];
            end
            2'd1: begin
                r = (a << 8) & ~64'h0000_00FF_0000_00FF;
                for (int k = 0; k < 2; k++) begin
                    v = longint'($signed(b[32*k +: 32]));
                    v = clampv((v <<< s5) >>> 23, 0, 255);
                    r[32*k +: 8] = v[7:0];
                end
            end
            2'd2: for (int k = 0; k < 2; k++) begin
                v = longint'($signed(b[32*k +: 32]));
                v = clampv((v <<< s5) >>> 16, -32768, 32767);
                r[16*k +: 16] = v[15:0];
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic compare();
        n_checks++;
        if (out_valid !== exp_valid || out_data !== exp_data) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b data=%h, expected valid=%0b data=%h",
                     exp_tag, out_valid, out_data, exp_valid, exp_data);
        end
    endtask

    // Compare the current output, then drive the next cycle and update the model.
    task automatic drive(bit v, logic [1:0] op, logic [63:0] g,
                         logic [63:0] a, logic [63:0] b, string tag);
        @(negedge clk);
        compare();
        in_valid = v; op_sel = op; status = g; merge_src = a; lane_src = b;
        if (v) begin
            exp_valid = 1; exp_data = ref_pack(op, g, a, b); exp_tag = tag;
        end else begin
            exp_valid = 0; exp_tag = "R2";
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got hung run, expected completion");
        finish_run();
    end

    initial begin
        // R1: outputs cleared under reset, even with valid input pending.
        in_valid = 1'b1; op_sel = 2'd2; lane_src = 64'h7FFF_FFFF_7FFF_FFFF;
        repeat (3) @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || out_data !== 64'd0) begin
            n_fail++;
            $display("FAIL R1: got valid=%0b data=%h, expected valid=0 data=0", out_valid, out_data);
        end
        in_valid = 1'b0;
        rst_n = 1'b1;

        // R3: clamp edges at scale 0 (1, 255 exact, negative to 0, 127).
        drive(1, 2'd0, 64'h0, 64'h0, 64'h3F80_FFFF_7FFF_0080, "R3");
        // R3: scale 15 pushes 1 to 256 -> 255, and 0x00FF to saturation.
        drive(1, 2'd0, 64'h78, 64'h0, 64'h0000_00FF_FFFE_0001, "R3");
        // R4: every status bit outside [6:3] set; scale field 2.
        drive(1, 2'd0, 64'hFFFF_FFFF_FFFF_FF97, 64'h0, 64'h0100_0200_0040_0020, "R4");
        // R2: idle gap holds data.
        drive(0, 2'd0, 64'h0, 64'h0, 64'h0, "R2");
        drive(0, 2'd1, 64'hFF, 64'hFF, 64'hFF, "R2");
        // R5/R6: merge pattern with exact 255 and overflow lanes.
        drive(1, 2'd1, 64'h0, 64'h1122_3344_5566_7788, 64'h8000_0000_7FFF_FFFF, "R6");
        drive(1, 2'd1, 64'h40, 64'hA5A5_A5A5_5A5A_5A5A, 64'h0000_0100_0000_0080, "R5");
        drive(1, 2'd1, 64'hFFFF_FFFF_FFFF_FF07, 64'hFFFF_FFFF_FFFF_FFFF, 64'h007F_8000_0080_0000, "R5");
        // R7: negative and positive saturation, in-range values.
        drive(1, 2'd2, 64'h8, 64'h0, 64'h8000_0000_7FFF_FFFF, "R7");
        drive(1, 2'd2, 64'h0, 64'h0, 64'hFFFF_0000_1234_5678, "R7");
        // R8: large lanes with scale 31 must saturate, not wrap.
        drive(1, 2'd2, 64'hF8, 64'h0, 64'hC000_0000_4000_0000, "R8");
        drive(1, 2'd1, 64'hF8, 64'h0, 64'h0000_0002_0000_0001, "R8");
        drive(1, 2'd0, 64'h78, 64'h0, 64'h4000_8000_0100_0002, "R8");
        // R9: reserved op gives zero.
        drive(1, 2'd3, 64'hFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R9");
        // Random mix with back-to-back and idle cycles.
        for (int i = 0; i < 400; i++) begin
            logic [1:0] op = 2'($urandom_range(0, 3));
            logic [63:0] g = {$urandom, $urandom};
            logic [63:0] a = {$urandom, $urandom};
            logic [63:0] b = {$urandom, $urandom};
            bit v = ($urandom_range(0, 3) != 0);
            string t = (op == 2'd0) ? "R3" : (op == 2'd1) ? "R5" : (op == 2'd2) ? "R7" : "R9";
            drive(v, op, g, a, b, t);
        end
        drive(0, 2'd0, 64'h0, 64'h0, 64'h0, "R2");
        drive(0, 2'd0, 64'h0, 64'h0, 64'h0, "R2");
        finish_run();
    end
endmodule